// File: doc/BRIEF.md
# Two-Pattern Delay Test Sequencer

This block runs a timed two-vector test against a combinational block under test. Once a start request is accepted, it drives an initializing vector onto the drive bus and holds it for a programmable number of settle cycles. It then switches every drive bit to the second vector on a single clock edge. After a programmable launch-to-capture interval, it samples the capture bus and compares it with an expected response word.

A path whose delay is longer than the capture interval still shows a stale value at the sampling edge. The compare then reports that value as a fail. A mask of the mismatching bits stays readable until the next test is started. Because the interval is a cycle count chosen per test, a test can be run at the rated interval or at a tighter one.

Top module: `dly2p_seq`

## Requirements
- R1: While reset is asserted and after it is released, `dut_drive` is all zeros, and `busy`, `done`, `pass`, `fail` and `fail_mask` are all zero until the first accepted start.
- R2: A `start` sampled high while not busy is accepted on that edge. From the next cycle, `dut_drive` carries `v1_vec` for exactly `settle_cyc` cycles. A value of 0 is treated as 1.
- R3: All bits of `dut_drive` change from V1 to `v2_vec` on one edge, `settle_cyc` edges after acceptance. V2 is then held until the next accepted start.
- R4: `dut_capture` is sampled on the edge exactly `cap_ivl` cycles after the V2 edge. A value of 0 is treated as 1. `busy` falls on that same edge.
- R5: After the capture edge, `fail` is 1 if any captured bit differs from `exp_resp`, and `pass` is 1 otherwise. The two are never both high. A path slower than the interval therefore produces `fail`.
- R6: `fail_mask` is the bitwise XOR of `exp_resp` and the captured word. It holds until the next accepted start, which clears it along with `pass` and `fail`.
- R7: `busy` is high from the cycle after acceptance up to the capture edge. A `start` seen while busy has no effect on the drive sequence or the result.
- R8: `done` is high for exactly one cycle, the cycle after the capture edge.
- R9: `v1_vec`, `v2_vec`, `exp_resp`, `settle_cyc` and `cap_ivl` are taken only at acceptance. Changing them while busy does not alter the test in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request to begin a test |
| v1_vec | input | DW | Initializing vector |
| v2_vec | input | DW | Launch vector |
| exp_resp | input | CW | Expected response to V2 |
| settle_cyc | input | CNTW | Cycles V1 is held (0 acts as 1) |
| cap_ivl | input | CNTW | Launch-to-capture cycles (0 acts as 1) |
| dut_drive | output | DW | Drive bus to the block under test |
| dut_capture | input | CW | Output bus of the block under test |
| busy | output | 1 | Test in progress |
| done | output | 1 | One-cycle completion pulse |
| pass | output | 1 | Last test matched |
| fail | output | 1 | Last test mismatched |
| fail_mask | output | CW | Mismatching bits of the last test |

## Verification
The bench models the block under test as a complemented copy of the drive bus seen through a selectable number of cycle delays. This lets a slow path be placed one cycle either side of the capture interval. A design that samples one edge early or late then reports a pass where a fail is due, or the reverse.

Zero settle and zero interval counts are exercised. A design that counted them literally would hang or launch V2 on the same edge as V1.

A second start with different operands is issued mid-test. A design that re-armed or re-latched would change the drive sequence or the mask. The mask is also watched across idle cycles, because a design that cleared it early would lose the result.

// File: rtl/dly2p_pkg.sv
package dly2p_pkg;

  typedef enum logic [1:0] {
    PH_IDLE   = 2'd0,
    PH_SETTLE = 2'd1,
    PH_FLIGHT = 2'd2
  } phase_t;

  // A programmed count of zero is promoted to one cycle.
  function automatic logic [31:0] at_least_one(input logic [31:0] n);
    return (n == 32'd0) ? 32'd1 : n;
  endfunction

endpackage

// File: rtl/dly2p_ctrl.sv
module dly2p_ctrl
  import dly2p_pkg::*;
#(
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [CNTW-1:0] settle_cyc,
  input  logic [CNTW-1:0] cap_ivl,
  output logic            busy,
  output logic            accept_evt,
  output logic            launch_evt,
  output logic            capture_evt
);

  phase_t          phase_q;
  logic [CNTW-1:0] cnt_q;
  logic [CNTW-1:0] ivl_q;
  logic [CNTW-1:0] settle_eff;
  logic [CNTW-1:0] ivl_eff;
  logic            cnt_last;

  assign settle_eff = CNTW'(at_least_one(32'(settle_cyc)));
  assign ivl_eff    = CNTW'(at_least_one(32'(cap_ivl)));
  assign cnt_last   = (cnt_q == CNTW'(1));

  assign busy        = (phase_q != PH_IDLE);
  assign accept_evt  = (phase_q == PH_IDLE) && start;
  assign launch_evt  = (phase_q == PH_SETTLE) && cnt_last;
  assign capture_evt = (phase_q == PH_FLIGHT) && cnt_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      ivl_q   <= '0;
    end else begin
      unique case (phase_q)
        PH_IDLE: begin
          if (start) begin
            phase_q <= PH_SETTLE;
            cnt_q   <= settle_eff;
            ivl_q   <= ivl_eff;
          end
        end
        PH_SETTLE: begin
          if (cnt_last) begin
            phase_q <= PH_FLIGHT;
            cnt_q   <= ivl_q;
          end else begin
            cnt_q <= cnt_q - CNTW'(1);
          end
        end
        PH_FLIGHT: begin
          if (cnt_last) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
          end else begin
            cnt_q <= cnt_q - CNTW'(1);
          end
        end
        default: phase_q <= PH_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/dly2p_drive.sv
module dly2p_drive #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_evt,
  input  logic          launch_evt,
  input  logic [DW-1:0] v1_vec,
  input  logic [DW-1:0] v2_vec,
  output logic [DW-1:0] dut_drive
);

  logic [DW-1:0] v2_q;

  // One register holds the whole bus so every bit launches on one edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dut_drive <= '0;
      v2_q      <= '0;
    end else if (accept_evt) begin
      dut_drive <= v1_vec;
      v2_q      <= v2_vec;
    end else if (launch_evt) begin
      dut_drive <= v2_q;
    end
  end

endmodule

// File: rtl/dly2p_cmp.sv
module dly2p_cmp #(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          accept_evt,
  input  logic          capture_evt,
  input  logic [CW-1:0] exp_resp,
  input  logic [CW-1:0] dut_capture,
  output logic          pass,
  output logic          fail,
  output logic          done,
  output logic [CW-1:0] fail_mask
);

  logic [CW-1:0] exp_q;
  logic [CW-1:0] diff;

  function automatic logic [CW-1:0] diff_bits(input logic [CW-1:0] a,
                                              input logic [CW-1:0] b);
    return a ^ b;
  endfunction

  assign diff = diff_bits(exp_q, dut_capture);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exp_q     <= '0;
      pass      <= 1'b0;
      fail      <= 1'b0;
      done      <= 1'b0;
      fail_mask <= '0;
    end else begin
      done <= capture_evt;
      if (accept_evt) begin
        exp_q     <= exp_resp;
        pass      <= 1'b0;
        fail      <= 1'b0;
        fail_mask <= '0;
      end else if (capture_evt) begin
        fail_mask <= diff;
        fail      <= |diff;
        pass      <= ~|diff;
      end
    end
  end

endmodule

// File: rtl/dly2p_seq.sv
module dly2p_seq #(
  parameter int DW   = 8,
  parameter int CW   = 8,
  parameter int CNTW = 8
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [DW-1:0]   v1_vec,
  input  logic [DW-1:0]   v2_vec,
  input  logic [CW-1:0]   exp_resp,
  input  logic [CNTW-1:0] settle_cyc,
  input  logic [CNTW-1:0] cap_ivl,
  output logic [DW-1:0]   dut_drive,
  input  logic [CW-1:0]   dut_capture,
  output logic            busy,
  output logic            done,
  output logic            pass,
  output logic            fail,
  output logic [CW-1:0]   fail_mask
);

  logic accept_evt;
  logic launch_evt;
  logic capture_evt;

  dly2p_ctrl #(.CNTW(CNTW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start),
    .settle_cyc(settle_cyc), .cap_ivl(cap_ivl),
    .busy(busy), .accept_evt(accept_evt),
    .launch_evt(launch_evt), .capture_evt(capture_evt)
  );

  dly2p_drive #(.DW(DW)) u_drive (
    .clk(clk), .rst_n(rst_n), .accept_evt(accept_evt),
    .launch_evt(launch_evt), .v1_vec(v1_vec), .v2_vec(v2_vec),
    .dut_drive(dut_drive)
  );

  dly2p_cmp #(.CW(CW)) u_cmp (
    .clk(clk), .rst_n(rst_n), .accept_evt(accept_evt),
    .capture_evt(capture_evt), .exp_resp(exp_resp),
    .dut_capture(dut_capture), .pass(pass), .fail(fail),
    .done(done), .fail_mask(fail_mask)
  );

endmodule

// File: rtl/dly2p_seq_chk.sv
module dly2p_seq_chk #(
  parameter int DW = 8,
  parameter int CW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          pass,
  input logic          fail,
  input logic [CW-1:0] fail_mask,
  input logic [DW-1:0] dut_drive,
  input logic          accept_evt,
  input logic          launch_evt,
  input logic          capture_evt
);

  assert_drive_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!accept_evt && !launch_evt) |=> $stable(dut_drive));

  assert_busy_drop_R4: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> !busy);

  assert_pass_fail_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(pass && fail));

  assert_mask_agrees_R6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (fail == (|fail_mask)));

  assert_no_accept_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !accept_evt);

  assert_done_follows_R8: assert property (@(posedge clk) disable iff (!rst_n)
    capture_evt |=> done);

  assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

endmodule

bind dly2p_seq dly2p_seq_chk #(.DW(DW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .pass(pass),
  .fail(fail), .fail_mask(fail_mask), .dut_drive(dut_drive),
  .accept_evt(accept_evt), .launch_evt(launch_evt),
  .capture_evt(capture_evt)
);

// File: tb/dly2p_seq_tb.sv
module dly2p_seq_tb;

  localparam int DW = 8;
  localparam int CW = 8;
  localparam int CNTW = 8;
  localparam int DL = 6;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [DW-1:0]   v1_vec = '0;
  logic [DW-1:0]   v2_vec = '0;
  logic [CW-1:0]   exp_resp = '0;
  logic [CNTW-1:0] settle_cyc = '0;
  logic [CNTW-1:0] cap_ivl = '0;
  logic [DW-1:0]   dut_drive;
  logic [CW-1:0]   dut_capture;
  logic            busy, done, pass, fail;
  logic [CW-1:0]   fail_mask;

  int n_tests = 0;
  int n_fail  = 0;
  int pdly    = 0;

  always #2 clk = ~clk;

  dly2p_seq #(.DW(DW), .CW(CW), .CNTW(CNTW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .v1_vec(v1_vec),
    .v2_vec(v2_vec), .exp_resp(exp_resp), .settle_cyc(settle_cyc),
    .cap_ivl(cap_ivl), .dut_drive(dut_drive), .dut_capture(dut_capture),
    .busy(busy), .done(done), .pass(pass), .fail(fail),
    .fail_mask(fail_mask)
  );

  // Block under test: complement of the drive bus after pdly cycles.
  logic [DW-1:0] dline [DL];
  always @(posedge clk) begin
    dline[0] <= dut_drive;
    for (int i = 1; i < DL; i++) dline[i] <= dline[i-1];
  end
  assign dut_capture = (pdly == 0) ? ~dut_drive : ~dline[pdly-1];

  // Behavioural reference model.
  int          m_state = 0;
  int          m_cnt = 0;
  int          m_tc = 0;
  logic [7:0]  m_v2 = 0, m_exp = 0;
  logic [7:0]  m_drive = 0, m_mask = 0;
  bit          m_busy = 0, m_done = 0, m_pass = 0, m_fail = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_state = 0; m_drive = 0; m_mask = 0;
      m_busy = 0; m_done = 0; m_pass = 0; m_fail = 0;
    end else begin
      m_done = 0;
      if (m_state == 0) begin
        if (start) begin
          m_state = 1;
          m_drive = v1_vec;
          m_v2 = v2_vec;
          m_exp = exp_resp;
          m_cnt = (settle_cyc == 0) ? 1 : int'(settle_cyc);
          m_tc = (cap_ivl == 0) ? 1 : int'(cap_ivl);
          m_busy = 1; m_pass = 0; m_fail = 0; m_mask = 0;
        end
      end else if (m_state == 1) begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_drive = m_v2;
          m_cnt = m_tc;
          m_state = 2;
        end
      end else begin
        m_cnt--;
        if (m_cnt == 0) begin
          m_mask = m_exp ^ dut_capture;
          m_fail = (m_mask != 0);
          m_pass = !m_fail;
          m_done = 1;
          m_busy = 0;
          m_state = 0;
        end
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s at %0t: actual %0h expected %0h", tag, $time, act, exp);
    end
  endtask

  always @(negedge clk) begin
    chk("R2/R3 drive", 32'(dut_drive), 32'(m_drive));
    chk("R7 busy", 32'(busy), 32'(m_busy));
    chk("R8 done", 32'(done), 32'(m_done));
    chk("R5 pass", 32'(pass), 32'(m_pass));
    chk("R5 fail", 32'(fail), 32'(m_fail));
    chk("R6 mask", 32'(fail_mask), 32'(m_mask));
  end

  task automatic run(input logic [7:0] a, input logic [7:0] b,
                     input logic [7:0] e, input int st, input int tc,
                     input int pd, input bit want_fail,
                     input logic [7:0] want_mask, input bit poke);
    @(negedge clk);
    pdly = pd;
    v1_vec = a; v2_vec = b; exp_resp = e;
    settle_cyc = CNTW'(st); cap_ivl = CNTW'(tc);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    if (poke) begin
      // R7 and R9: new operands and a start while busy must not matter.
      v1_vec = ~a; v2_vec = a; exp_resp = ~e;
      settle_cyc = 8'd9; cap_ivl = 8'd9;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    for (int i = 0; i < 200 && !done; i++) @(negedge clk);
    chk("R8 done seen", 32'(done), 32'd1);
    chk("R5 verdict fail", 32'(fail), 32'(want_fail));
    chk("R5 verdict pass", 32'(pass), 32'(!want_fail));
    chk("R6 mask value", 32'(fail_mask), 32'(want_mask));
    chk("R3 V2 held", 32'(dut_drive), 32'(b));
    repeat (3) @(negedge clk);
    chk("R6 mask kept", 32'(fail_mask), 32'(want_mask));
  endtask

  initial begin
    #(200000 * 4);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 drive in reset", 32'(dut_drive), 32'd0);
    chk("R1 flags in reset", {busy, done, pass, fail}, 32'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    chk("R1 mask after reset", 32'(fail_mask), 32'd0);
    // R2 R3 R4 nominal: fast path passes.
    run(8'h5A, 8'hC3, ~8'hC3, 3, 2, 0, 0, 8'h00, 0);
    // R2 R4 zero counts act as one.
    run(8'h0F, 8'hF0, ~8'hF0, 0, 0, 0, 0, 8'h00, 0);
    // R5 slow path beyond interval -> fail, stale V1 response captured.
    run(8'h33, 8'hCC, ~8'hCC, 2, 1, 1, 1, 8'hFF, 0);
    // R4 same path with enough interval passes.
    run(8'h33, 8'hCC, ~8'hCC, 2, 2, 1, 0, 8'h00, 0);
    // R5 R4 boundary: delay 3 needs interval 4.
    run(8'h01, 8'h80, ~8'h80, 4, 3, 3, 1, 8'h81, 0);
    run(8'h01, 8'h80, ~8'h80, 4, 4, 3, 0, 8'h00, 0);
    // R6 single-bit expected mismatch.
    run(8'hA5, 8'h5A, (~8'h5A) ^ 8'h10, 1, 2, 0, 1, 8'h10, 0);
    // R7 R9 start and operand changes while busy ignored.
    run(8'h12, 8'h34, ~8'h34, 5, 3, 0, 0, 8'h00, 1);
    // R6 mask cleared on the next accepted start.
    @(negedge clk);
    start = 1'b1; settle_cyc = 8'd4; cap_ivl = 8'd4;
    @(negedge clk);
    start = 1'b0;
    @(negedge clk);
    chk("R6 mask cleared", 32'(fail_mask), 32'd0);
    for (int i = 0; i < 50 && busy; i++) @(negedge clk);
    repeat (3) @(negedge clk);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

endmodule